// File: doc/BRIEF.md
# Endpoint Packet Buffer with Byte/Halfword CPU Port

This block holds the packet data of one USB endpoint between a microcontroller and the USB engine. The microcontroller reaches it through a 16-bit data port and may move one byte or two bytes per access. For a device-to-host endpoint the CPU fills a transmit buffer. The packet becomes ready for the USB side on its own once it reaches the programmed maximum packet size. The CPU can also close it early with a commit command, which sends a short or empty packet. For a host-to-device endpoint the USB side deposits a packet, and the CPU drains it through the same port. The buffer is released as soon as the last byte has been read.

A mode input selects single or double buffering. With double buffering, the CPU can work on one buffer while the USB side works on the other. A discard command empties one buffer per issue. The USB side is a plain byte strobe interface. On transmit it sees a ready flag, a byte count, the current byte and a read strobe. On receive it has a write strobe and an end-of-packet strobe.

Top module: `ep_pkt_buffer`

## Requirements
- R1: A CPU write in transmit mode stores cpuWdata[7:0] at the fill pointer. When cpuWide is 1 it also stores cpuWdata[15:8] at the next position. The pointer then advances by 2 for a wide access and by 1 for a narrow one. The USB side later reads the bytes in ascending position order.
- R2: A transmit buffer is marked ready (usbBufFull=1) with usbCount equal to the effective packet limit once the filled byte count reaches that limit. The effective limit is maxPkt. A maxPkt of 0, or one above MAX_PKT, counts as MAX_PKT.
- R3: cmdValidate marks the transmit buffer being filled as ready, with the number of bytes it holds. This is also allowed when it holds zero bytes.
- R4: A wide access with exactly one byte left before the limit (transmit) or before the packet end (receive) moves only that byte. The pointer advances by 1. On a read, cpuRdata[15:8] is 0.
- R5: A CPU write while the addressed transmit buffer is ready does not change its contents or count and sets overrun. Overrun stays set until the next cmdClear.
- R6: While usbBufFull is 1, usbRdata shows the next byte of the packet and each usbRd advances by one byte. The strobe that consumes the last byte frees the buffer. For an empty packet, a single usbRd frees it.
- R7: In receive mode each usbWr stores usbWdata at the next position, and usbEnd closes the packet with the number of bytes written. The CPU sees the packet through cpuBufFull=1. cpuRdata[7:0] is the byte at the read pointer. cpuRdata[15:8] is the following byte when cpuWide is 1, and 0 otherwise. Each cpuRd advances by the bytes shown.
- R8: A receive buffer is released, clearing cpuBufFull and usbBufFull in single mode, by the cpuRd that consumes its last byte.
- R9: With dblBuf=1, the CPU fills the second buffer while the first waits for the USB side. The USB side drains the buffers in the order they were committed.
- R10: cmdClear empties the buffer the CPU port addresses and clears overrun. If the other buffer still holds a packet, the CPU port moves to it. Otherwise both sides restart on the first buffer with empty pointers, so two commands are needed to empty both buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dirIn | input | 1 | 1: transmit (device to host), 0: receive |
| dblBuf | input | 1 | 1: two alternating buffers |
| maxPkt | input | CW | Packet size limit in bytes |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe (consumes shown bytes) |
| cpuWide | input | 1 | 1: 16-bit access, 0: 8-bit access |
| cpuWdata | input | 16 | CPU write data |
| cpuRdata | output | 16 | CPU read data at the read pointer |
| cmdValidate | input | 1 | Commit the partly filled transmit buffer |
| cmdClear | input | 1 | Discard one buffer |
| cpuBufFull | output | 1 | Buffer addressed by the CPU holds a committed packet |
| overrun | output | 1 | Sticky: write to a ready transmit buffer |
| usbRd | input | 1 | USB side consumes one transmit byte |
| usbWr | input | 1 | USB side stores one receive byte |
| usbEnd | input | 1 | USB side closes the receive packet |
| usbWdata | input | 8 | Receive byte from the USB side |
| usbRdata | output | 8 | Current transmit byte |
| usbBufFull | output | 1 | Buffer addressed by the USB side holds a committed packet |
| usbCount | output | CW | Byte count of that packet |

## Verification
The bench builds the block with MAX_PKT set to 16. This makes the clamped limit reachable with eight wide writes, so the out-of-range maxPkt rule is exercised without long fills. Small programmed limits of 2, 5, 7 and 8 bring the odd-remainder wide access, the zero-length commit and the filling of both buffers within a few cycles. Double-buffer runs cover draining order, and they cover the two-step discard followed by a fresh packet that must land on the first buffer.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;

  // Strobes from the control to the byte storage
  typedef struct packed {
    logic cpuWrLo;  // store low byte of the CPU word
    logic cpuWrHi;  // store high byte of the CPU word
    logic usbWrEn;  // store one received byte
    logic cpuRdLo;  // present low byte on the CPU port
    logic cpuRdHi;  // present high byte on the CPU port
  } dpStrobe_t;

endpackage

// File: rtl/epbuf_ctrl.sv
module epbuf_ctrl
  import epbuf_pkg::*;
#(
  parameter int MAX_PKT = 512,
  parameter int CW      = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dirIn,
  input  logic          dblBuf,
  input  logic [CW-1:0] maxPkt,
  input  logic          cpuWr,
  input  logic          cpuRd,
  input  logic          cpuWide,
  input  logic          cmdValidate,
  input  logic          cmdClear,
  input  logic          usbRd,
  input  logic          usbWr,
  input  logic          usbEnd,
  output dpStrobe_t     strb,
  output logic          cpuBank,
  output logic          usbBank,
  output logic [CW-1:0] cpuPtr,
  output logic [CW-1:0] usbPtr,
  output logic          cpuBufFull,
  output logic          usbBufFull,
  output logic [CW-1:0] usbCount,
  output logic          overrun
);

  localparam logic [CW-1:0] LIMIT = CW'(MAX_PKT);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] TWO   = CW'(2);

  logic [1:0]    full, fullN;
  logic [CW-1:0] cnt  [2];
  logic [CW-1:0] cntN [2];
  logic          cpuBankN, usbBankN, overrunN;
  logic [CW-1:0] cpuPtrN, usbPtrN;

  logic [CW-1:0] effMax, remain, ptrNext;
  logic twoBytes, usbLast, otherFull;
  logic txWrOk, txWrBlk, txValOk, rxRdOk, usbRdOk, usbWrOk, usbEndOk;

  assign effMax     = (maxPkt == '0 || maxPkt > LIMIT) ? LIMIT : maxPkt;
  assign cpuBufFull = full[cpuBank];
  assign usbBufFull = full[usbBank];
  assign usbCount   = cnt[usbBank];

  assign remain   = dirIn ? (effMax - cpuPtr) : (cnt[cpuBank] - cpuPtr);
  assign twoBytes = cpuWide && (remain >= TWO);
  assign ptrNext  = cpuPtr + (twoBytes ? TWO : ONE);
  assign usbLast  = (usbPtr + ONE) >= cnt[usbBank];
  assign otherFull = dblBuf && full[~cpuBank];

  assign txWrOk   = dirIn && cpuWr && !cpuBufFull && !cmdClear;
  assign txWrBlk  = dirIn && cpuWr && cpuBufFull && !cmdClear;
  assign txValOk  = dirIn && cmdValidate && !cpuBufFull && !cmdClear;
  assign rxRdOk   = !dirIn && cpuRd && cpuBufFull && !cmdClear;
  assign usbRdOk  = dirIn && usbRd && usbBufFull && !cmdClear;
  assign usbWrOk  = !dirIn && usbWr && !usbBufFull && (usbPtr < effMax) && !cmdClear;
  assign usbEndOk = !dirIn && usbEnd && !usbBufFull && !cmdClear;

  always_comb begin
    strb.cpuWrLo = txWrOk;
    strb.cpuWrHi = txWrOk && twoBytes;
    strb.usbWrEn = usbWrOk;
    strb.cpuRdLo = !dirIn && cpuBufFull && (remain != '0);
    strb.cpuRdHi = !dirIn && cpuBufFull && twoBytes;
  end

  always_comb begin
    fullN    = full;
    cntN     = cnt;
    cpuBankN = cpuBank;
    usbBankN = usbBank;
    cpuPtrN  = cpuPtr;
    usbPtrN  = usbPtr;
    overrunN = overrun;
    if (cmdClear) begin
      fullN[cpuBank] = 1'b0;
      cntN[cpuBank]  = '0;
      cpuPtrN        = '0;
      overrunN       = 1'b0;
      if (usbBank == cpuBank) usbPtrN = '0;
      if (otherFull) begin
        cpuBankN = ~cpuBank;
      end else begin
        cpuBankN = 1'b0;
        usbBankN = 1'b0;
        usbPtrN  = '0;
      end
    end else begin
      // CPU side
      if (txWrOk) begin
        if (ptrNext == effMax || cmdValidate) begin
          fullN[cpuBank] = 1'b1;
          cntN[cpuBank]  = ptrNext;
          cpuPtrN        = '0;
          cpuBankN       = dblBuf & ~cpuBank;
        end else begin
          cpuPtrN = ptrNext;
        end
      end else if (txValOk) begin
        fullN[cpuBank] = 1'b1;
        cntN[cpuBank]  = cpuPtr;
        cpuPtrN        = '0;
        cpuBankN       = dblBuf & ~cpuBank;
      end
      if (txWrBlk) overrunN = 1'b1;
      if (rxRdOk) begin
        if (ptrNext >= cnt[cpuBank]) begin
          fullN[cpuBank] = 1'b0;
          cntN[cpuBank]  = '0;
          cpuPtrN        = '0;
          cpuBankN       = dblBuf & ~cpuBank;
        end else begin
          cpuPtrN = ptrNext;
        end
      end
      // USB side
      if (usbRdOk) begin
        if (usbLast) begin
          fullN[usbBank] = 1'b0;
          cntN[usbBank]  = '0;
          usbPtrN        = '0;
          usbBankN       = dblBuf & ~usbBank;
        end else begin
          usbPtrN = usbPtr + ONE;
        end
      end
      if (usbWrOk) usbPtrN = usbPtr + ONE;
      if (usbEndOk) begin
        fullN[usbBank] = 1'b1;
        cntN[usbBank]  = usbPtr + (usbWrOk ? ONE : '0);
        usbPtrN        = '0;
        usbBankN       = dblBuf & ~usbBank;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full    <= '0;
      cnt[0]  <= '0;
      cnt[1]  <= '0;
      cpuBank <= 1'b0;
      usbBank <= 1'b0;
      cpuPtr  <= '0;
      usbPtr  <= '0;
      overrun <= 1'b0;
    end else begin
      full    <= fullN;
      cnt[0]  <= cntN[0];
      cnt[1]  <= cntN[1];
      cpuBank <= cpuBankN;
      usbBank <= usbBankN;
      cpuPtr  <= cpuPtrN;
      usbPtr  <= usbPtrN;
      overrun <= overrunN;
    end
  end

  // R1
  wide_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirIn && cpuWr && cpuWide && !cpuBufFull && !cmdClear && !cmdValidate && (remain > TWO)
    |=> cpuPtr == $past(cpuPtr) + TWO);

  // R2
  auto_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dblBuf && dirIn && cpuWr && !cpuBufFull && !cmdClear && (ptrNext == effMax)
    |=> usbBufFull && (usbCount == $past(effMax)));

  // R5
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(dirIn && cpuWr && cpuBufFull && !cmdClear));

  // R8
  rx_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dblBuf && !dirIn && cpuRd && cpuBufFull && !cmdClear && (ptrNext >= cnt[cpuBank])
    |=> !cpuBufFull);

  // R10
  single_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dblBuf && cmdClear |=> !cpuBufFull && !usbBufFull && !overrun);

endmodule

// File: rtl/epbuf_data.sv
module epbuf_data
  import epbuf_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  dpStrobe_t     strb,
  input  logic          cpuBank,
  input  logic [AW-1:0] cpuAddr,
  input  logic          usbBank,
  input  logic [AW-1:0] usbAddr,
  input  logic [15:0]   cpuWdata,
  input  logic [7:0]    usbWdata,
  output logic [15:0]   cpuRdata,
  output logic [7:0]    usbRdata
);

  localparam int DEPTH = 2 << AW;

  logic [7:0] mem [DEPTH];
  logic [AW:0] loIdx, hiIdx, usbIdx;

  assign loIdx  = {cpuBank, cpuAddr};
  assign hiIdx  = {cpuBank, cpuAddr + AW'(1)};
  assign usbIdx = {usbBank, usbAddr};

  always_ff @(posedge clk) begin
    if (strb.cpuWrLo) mem[loIdx]  <= cpuWdata[7:0];
    if (strb.cpuWrHi) mem[hiIdx]  <= cpuWdata[15:8];
    if (strb.usbWrEn) mem[usbIdx] <= usbWdata;
  end

  assign cpuRdata = {strb.cpuRdHi ? mem[hiIdx] : 8'h00,
                     strb.cpuRdLo ? mem[loIdx] : 8'h00};
  assign usbRdata = mem[usbIdx];

endmodule

// File: rtl/ep_pkt_buffer.sv
module ep_pkt_buffer
  import epbuf_pkg::*;
#(
  parameter int MAX_PKT = 512,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = $clog2(MAX_PKT)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dirIn,
  input  logic          dblBuf,
  input  logic [CW-1:0] maxPkt,
  input  logic          cpuWr,
  input  logic          cpuRd,
  input  logic          cpuWide,
  input  logic [15:0]   cpuWdata,
  output logic [15:0]   cpuRdata,
  input  logic          cmdValidate,
  input  logic          cmdClear,
  output logic          cpuBufFull,
  output logic          overrun,
  input  logic          usbRd,
  input  logic          usbWr,
  input  logic          usbEnd,
  input  logic [7:0]    usbWdata,
  output logic [7:0]    usbRdata,
  output logic          usbBufFull,
  output logic [CW-1:0] usbCount
);

  dpStrobe_t     strb;
  logic          cpuBank, usbBank;
  logic [CW-1:0] cpuPtr, usbPtr;

  epbuf_ctrl #(.MAX_PKT(MAX_PKT), .CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .dirIn(dirIn), .dblBuf(dblBuf), .maxPkt(maxPkt),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuWide(cpuWide),
    .cmdValidate(cmdValidate), .cmdClear(cmdClear),
    .usbRd(usbRd), .usbWr(usbWr), .usbEnd(usbEnd),
    .strb(strb), .cpuBank(cpuBank), .usbBank(usbBank),
    .cpuPtr(cpuPtr), .usbPtr(usbPtr),
    .cpuBufFull(cpuBufFull), .usbBufFull(usbBufFull),
    .usbCount(usbCount), .overrun(overrun)
  );

  epbuf_data #(.AW(AW)) uData (
    .clk(clk), .strb(strb),
    .cpuBank(cpuBank), .cpuAddr(cpuPtr[AW-1:0]),
    .usbBank(usbBank), .usbAddr(usbPtr[AW-1:0]),
    .cpuWdata(cpuWdata), .usbWdata(usbWdata),
    .cpuRdata(cpuRdata), .usbRdata(usbRdata)
  );

endmodule

// File: tb/tb_ep_pkt_buffer.sv
module tb_ep_pkt_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_PKT = 16;
  localparam int CW = $clog2(MAX_PKT + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirIn = 1'b1, dblBuf = 1'b0;
  logic [CW-1:0] maxPkt = '0;
  logic cpuWr = 1'b0, cpuRd = 1'b0, cpuWide = 1'b0;
  logic [15:0] cpuWdata = '0;
  logic [15:0] cpuRdata;
  logic cmdValidate = 1'b0, cmdClear = 1'b0;
  logic cpuBufFull, overrun;
  logic usbRd = 1'b0, usbWr = 1'b0, usbEnd = 1'b0;
  logic [7:0] usbWdata = '0;
  logic [7:0] usbRdata;
  logic usbBufFull;
  logic [CW-1:0] usbCount;

  int vecs = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_pkt_buffer #(.MAX_PKT(MAX_PKT)) dut (
    .clk(clk), .rstN(rstN), .dirIn(dirIn), .dblBuf(dblBuf), .maxPkt(maxPkt),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuWide(cpuWide), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .cmdValidate(cmdValidate), .cmdClear(cmdClear),
    .cpuBufFull(cpuBufFull), .overrun(overrun), .usbRd(usbRd), .usbWr(usbWr),
    .usbEnd(usbEnd), .usbWdata(usbWdata), .usbRdata(usbRdata),
    .usbBufFull(usbBufFull), .usbCount(usbCount)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpuW(input logic w, input logic [15:0] d);
    @(negedge clk); cpuWr = 1'b1; cpuWide = w; cpuWdata = d;
    @(negedge clk); cpuWr = 1'b0; #1;
  endtask

  task automatic cpuR(input logic w, output logic [15:0] d);
    @(negedge clk); cpuWide = w; #1; d = cpuRdata; cpuRd = 1'b1;
    @(negedge clk); cpuRd = 1'b0; #1;
  endtask

  task automatic usbR(output logic [7:0] d);
    @(negedge clk); #1; d = usbRdata; usbRd = 1'b1;
    @(negedge clk); usbRd = 1'b0; #1;
  endtask

  task automatic usbW(input logic [7:0] d, input logic last);
    @(negedge clk); usbWr = 1'b1; usbEnd = last; usbWdata = d;
    @(negedge clk); usbWr = 1'b0; usbEnd = 1'b0; #1;
  endtask

  task automatic doValidate();
    @(negedge clk); cmdValidate = 1'b1;
    @(negedge clk); cmdValidate = 1'b0; #1;
  endtask

  task automatic doClear();
    @(negedge clk); cmdClear = 1'b1;
    @(negedge clk); cmdClear = 1'b0; #1;
  endtask

  task automatic setup(input logic dir, input logic dbl, input int mp);
    @(negedge clk); dirIn = dir; dblBuf = dbl; maxPkt = CW'(mp); #1;
  endtask

  task automatic testReset();
    chk("R6 reset usbBufFull", usbBufFull, 0);
    chk("R7 reset cpuBufFull", cpuBufFull, 0);
    chk("R5 reset overrun", overrun, 0);
    chk("R2 reset usbCount", usbCount, 0);
  endtask

  task automatic testTxMixed();  // R1 R2 R6
    logic [7:0] b;
    logic [7:0] exp [7] = '{8'hA0, 8'hB0, 8'hA1, 8'hA2, 8'hB2, 8'hA3, 8'hB3};
    setup(1'b1, 1'b0, 7);
    cpuW(1'b1, 16'hB0A0);
    cpuW(1'b0, 16'hEEA1);
    cpuW(1'b1, 16'hB2A2);
    chk("R2 not ready below limit", usbBufFull, 0);
    cpuW(1'b1, 16'hB3A3);
    chk("R2 ready at limit", usbBufFull, 1);
    chk("R2 count at limit", usbCount, 7);
    for (int i = 0; i < 7; i++) begin
      usbR(b);
      chk($sformatf("R1 byte %0d order", i), b, exp[i]);
    end
    chk("R6 freed after last byte", usbBufFull, 0);
  endtask

  task automatic testOddTail();  // R4
    logic [7:0] b;
    setup(1'b1, 1'b0, 5);
    cpuW(1'b1, 16'h1110);
    cpuW(1'b1, 16'h1312);
    chk("R4 not ready with one byte left", usbBufFull, 0);
    cpuW(1'b1, 16'h9914);
    chk("R4 ready after truncated write", usbBufFull, 1);
    chk("R4 count exact", usbCount, 5);
    for (int i = 0; i < 5; i++) begin
      usbR(b);
      chk("R4 tail data", b, 8'h10 + 8'(i));
    end
    chk("R6 freed", usbBufFull, 0);
  endtask

  task automatic testShort();  // R3 R6
    logic [7:0] b;
    setup(1'b1, 1'b0, 8);
    cpuW(1'b1, 16'h2120);
    doValidate();
    chk("R3 short ready", usbBufFull, 1);
    chk("R3 short count", usbCount, 2);
    usbR(b); chk("R3 short byte0", b, 8'h20);
    usbR(b); chk("R3 short byte1", b, 8'h21);
    chk("R6 short freed", usbBufFull, 0);
    doValidate();
    chk("R3 empty packet ready", usbBufFull, 1);
    chk("R3 empty packet count", usbCount, 0);
    usbR(b);
    chk("R6 empty packet freed by one strobe", usbBufFull, 0);
  endtask

  task automatic testOverrun();  // R5 R10
    logic [7:0] b;
    setup(1'b1, 1'b0, 2);
    cpuW(1'b1, 16'h3130);
    chk("R5 ready", usbBufFull, 1);
    chk("R5 no overrun yet", overrun, 0);
    cpuW(1'b1, 16'h5150);
    chk("R5 overrun set", overrun, 1);
    chk("R5 count unchanged", usbCount, 2);
    usbR(b); chk("R5 byte0 kept", b, 8'h30);
    usbR(b); chk("R5 byte1 kept", b, 8'h31);
    chk("R5 overrun sticky", overrun, 1);
    doClear();
    chk("R10 clear drops overrun", overrun, 0);
    chk("R10 single clear empty", cpuBufFull, 0);
  endtask

  task automatic testRx();  // R7 R8 R4
    logic [15:0] d;
    setup(1'b0, 1'b0, 16);
    for (int i = 0; i < 5; i++) usbW(8'h40 + 8'(i), i == 4);
    chk("R7 rx packet visible", cpuBufFull, 1);
    chk("R7 rx count", usbCount, 5);
    cpuR(1'b1, d); chk("R7 rx word0", d, 16'h4140);
    cpuR(1'b1, d); chk("R7 rx word1", d, 16'h4342);
    chk("R8 still held before last byte", cpuBufFull, 1);
    cpuR(1'b1, d); chk("R4 rx single tail byte", d, 16'h0044);
    chk("R8 rx released", cpuBufFull, 0);
    chk("R8 rx usb side free", usbBufFull, 0);
    for (int i = 0; i < 3; i++) usbW(8'h50 + 8'(i), i == 2);
    cpuR(1'b0, d); chk("R7 narrow read", d, 16'h0050);
    cpuR(1'b1, d); chk("R7 wide after narrow", d, 16'h5251);
    chk("R8 second release", cpuBufFull, 0);
  endtask

  task automatic testDouble();  // R9
    logic [7:0] b;
    setup(1'b1, 1'b1, 2);
    cpuW(1'b1, 16'h6160);
    chk("R9 first ready", usbBufFull, 1);
    chk("R9 cpu moves to free buffer", cpuBufFull, 0);
    cpuW(1'b1, 16'h6362);
    chk("R9 both occupied", cpuBufFull, 1);
    usbR(b); chk("R9 first packet byte0", b, 8'h60);
    usbR(b); chk("R9 first packet byte1", b, 8'h61);
    chk("R9 second packet waiting", usbBufFull, 1);
    chk("R9 cpu buffer free again", cpuBufFull, 0);
    usbR(b); chk("R9 second packet byte0", b, 8'h62);
    usbR(b); chk("R9 second packet byte1", b, 8'h63);
    chk("R9 all drained", usbBufFull, 0);
  endtask

  task automatic testDoubleClear();  // R10
    logic [7:0] b;
    setup(1'b1, 1'b1, 2);
    cpuW(1'b1, 16'h7170);
    cpuW(1'b0, 16'h0072);
    doClear();
    chk("R10 first clear keeps ready packet", usbBufFull, 1);
    chk("R10 cpu moved to held packet", cpuBufFull, 1);
    doClear();
    chk("R10 second clear empties all", usbBufFull, 0);
    chk("R10 cpu side empty", cpuBufFull, 0);
    cpuW(1'b1, 16'h7574);
    chk("R10 fresh packet ready", usbBufFull, 1);
    usbR(b); chk("R10 fresh packet first byte", b, 8'h74);
    usbR(b); chk("R10 fresh packet second byte", b, 8'h75);
  endtask

  task automatic testClamp();  // R2
    logic [7:0] b;
    setup(1'b1, 1'b0, 0);
    for (int i = 0; i < 7; i++) cpuW(1'b1, 16'h0101 * 16'(i));
    chk("R2 clamp not ready at 14", usbBufFull, 0);
    cpuW(1'b1, 16'h0707);
    chk("R2 clamp ready at MAX_PKT", usbBufFull, 1);
    chk("R2 clamp count", usbCount, MAX_PKT);
    for (int i = 0; i < MAX_PKT; i++) usbR(b);
    chk("R6 clamp drained", usbBufFull, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    testTxMixed();
    testOddTail();
    testShort();
    testOverrun();
    testRx();
    testDouble();
    testDoubleClear();
    testClamp();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule